// File: doc/BRIEF.md
# MII Receive Frame Deframer

This block sits on the MAC side of a 4-bit media-independent receive path and runs on the recovered receive clock. On every edge it samples a nibble, a nibble-valid line and a receive-error line. Once the valid line rises it hunts for the start-of-frame delimiter. The delimiter crosses the interface as the nibble pair 0x5 then 0xD. Nibbles before the delimiter, preamble or not, are thrown away. After the delimiter, nibbles are paired into bytes, low half first, and each byte is presented as a one-cycle strobe.

A frame ends only when the valid line falls. The block then raises a one-cycle end strobe that carries two flags. The frame-error flag records any receive error seen while the frame was active. The alignment flag records a leftover half byte. A valid burst that ends before any delimiter produces no bytes and no end strobe. It produces a one-cycle "no delimiter" pulse instead. The logic is the same at 10 and 100 Mb/s because only the clock frequency changes.

There is no handshake at the output. A consumer must accept every strobe in the cycle it appears.

Top module: `mii_rx_deframer`

## Requirements
- R1: In the cycle after synchronous reset is released, out_valid, out_eof, out_no_sfd, out_sof, out_err and out_align_err are all 0.
- R2: Every nibble from the rise of mii_valid up to and including the delimiter pair (0x5 followed directly by 0xD, both with mii_valid high) is discarded, and no byte strobe appears before it. A 0xD that does not directly follow a 0x5 does not end the hunt.
- R3: After the delimiter, consecutive nibbles N0, N1 form the byte {N1, N0}: the first nibble is bits 3:0 and the second is bits 7:4.
- R4: out_sof is 1 together with the first byte of a frame and 0 on every other byte.
- R5: A byte strobe appears in the cycle after the clock edge that sampled its second nibble. Two strobes are never on consecutive cycles.
- R6: When mii_valid is sampled low after the delimiter, out_eof pulses for one cycle in the following cycle, with out_valid at 0. There is exactly one such pulse per frame.
- R7: out_align_err is 1 on the end strobe when an odd number of nibbles followed the delimiter. The unpaired nibble is dropped, and out_align_err is 0 at all other times.
- R8: If mii_valid falls before a delimiter, no byte and no end strobe are produced. out_no_sfd pulses for one cycle in the cycle after mii_valid is sampled low.
- R9: A frame whose mii_valid rises directly on the delimiter's 0x5 nibble, with no preamble, is received normally.
- R10: out_err is 1 on a byte when mii_error was high on either of its nibbles. On the end strobe, out_err is 1 when mii_error was high in any cycle with mii_valid high, from the rise of mii_valid through the last nibble. A receive error does not stop byte output.
- R11: mii_error while mii_valid is low has no effect: it produces no strobe and does not set the frame-error flag of the next frame.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Receive clock |
| rst | input | 1 | Synchronous reset, active high |
| mii_nib | input | 4 | Received nibble |
| mii_valid | input | 1 | Nibble valid, high for the whole frame |
| mii_error | input | 1 | Receive error indication |
| out_valid | output | 1 | One-cycle byte strobe |
| out_data | output | 8 | Assembled byte, valid with out_valid |
| out_sof | output | 1 | First byte of the frame |
| out_err | output | 1 | Byte error with out_valid, frame error with out_eof |
| out_eof | output | 1 | One-cycle end-of-frame strobe |
| out_align_err | output | 1 | Odd nibble count, valid with out_eof |
| out_no_sfd | output | 1 | One-cycle pulse: burst ended without delimiter |

## Verification
A wrong half-byte phase shows up at the first byte after the delimiter. That byte comes out with its nibbles swapped, or one cycle early or late, and the alignment flag on the end strobe is inverted. A hunt state that leaves too early shows up as preamble bytes 0x55 on the output. A hunt state that never leaves shows up as a no-delimiter pulse where an end strobe was expected. Both appear within a few cycles of the delimiter or of the fall of mii_valid. A sticky error flag that is not cleared between frames shows up on the next frame's end strobe. Every expected strobe is therefore matched with its exact cycle, its data and its flags.

// File: rtl/mii_rx_pkg.sv
package mii_rx_pkg;

    localparam int NIB_W  = 4;
    localparam int BYTE_W = 2 * NIB_W;

    localparam logic [NIB_W-1:0] PRE_NIB = 4'h5;
    localparam logic [NIB_W-1:0] SFD_HI  = 4'hD;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_HUNT = 2'd1,
        ST_DATA = 2'd2
    } rx_state_e;

    typedef struct packed {
        logic              valid;
        logic [BYTE_W-1:0] data;
        logic              sof;
        logic              err;
    } byte_out_t;

    typedef struct packed {
        logic eof;
        logic err;
        logic align;
    } frame_end_t;

    function automatic logic is_pre_nib(input logic [NIB_W-1:0] n);
        return n == PRE_NIB;
    endfunction

endpackage

// File: rtl/mii_rx_sfd_hunt.sv
module mii_rx_sfd_hunt
    import mii_rx_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic [NIB_W-1:0] nib,
    input  logic             nib_valid,
    output rx_state_e        state,
    output logic             sfd_hit,
    output logic             no_sfd
);

    logic prev_pre;

    // delimiter: a 0xD nibble directly after a 0x5 nibble, both valid
    assign sfd_hit = (state == ST_HUNT) && nib_valid && (nib == SFD_HI) && prev_pre;

    always_ff @(posedge clk) begin
        if (rst) begin
            state    <= ST_IDLE;
            prev_pre <= 1'b0;
            no_sfd   <= 1'b0;
        end else begin
            prev_pre <= nib_valid && is_pre_nib(nib);
            no_sfd   <= (state == ST_HUNT) && !nib_valid;
            unique case (state)
                ST_IDLE: if (nib_valid) state <= ST_HUNT;
                ST_HUNT: begin
                    if (!nib_valid)   state <= ST_IDLE;
                    else if (sfd_hit) state <= ST_DATA;
                end
                ST_DATA: if (!nib_valid) state <= ST_IDLE;
                default: state <= ST_IDLE;
            endcase
        end
    end

    // entering the data phase needs a valid 0xD nibble in the previous cycle
    assert_enter_data_R2: assert property (@(posedge clk) disable iff (rst)
        (state == ST_DATA && $past(state) != ST_DATA) |-> ($past(nib_valid) && $past(nib) == SFD_HI));

    // the no-delimiter pulse only follows a hunt that was cut short
    assert_nosfd_from_hunt_R8: assert property (@(posedge clk) disable iff (rst)
        no_sfd |-> ($past(state) == ST_HUNT && state == ST_IDLE));

endmodule

// File: rtl/mii_rx_nibble_pack.sv
module mii_rx_nibble_pack
    import mii_rx_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  rx_state_e        state,
    input  logic             sfd_hit,
    input  logic [NIB_W-1:0] nib,
    input  logic             nib_valid,
    input  logic             nib_err,
    output byte_out_t        byte_o,
    output frame_end_t       end_o
);

    logic             half;
    logic [NIB_W-1:0] lo_nib;
    logic             lo_err;
    logic             first;
    logic             frame_err;

    always_ff @(posedge clk) begin
        if (rst) begin
            half      <= 1'b0;
            lo_nib    <= '0;
            lo_err    <= 1'b0;
            first     <= 1'b0;
            frame_err <= 1'b0;
            byte_o    <= '0;
            end_o     <= '0;
        end else begin
            byte_o.valid <= 1'b0;
            byte_o.sof   <= 1'b0;
            byte_o.err   <= 1'b0;
            end_o        <= '0;

            // sticky frame error, armed when a burst starts
            if (state == ST_IDLE)
                frame_err <= nib_valid && nib_err;
            else if (nib_valid && nib_err)
                frame_err <= 1'b1;

            if (sfd_hit) begin
                half  <= 1'b0;
                first <= 1'b1;
            end else if (state == ST_DATA) begin
                if (!nib_valid) begin
                    end_o.eof   <= 1'b1;
                    end_o.err   <= frame_err;
                    end_o.align <= half;
                    half        <= 1'b0;
                end else if (!half) begin
                    lo_nib <= nib;
                    lo_err <= nib_err;
                    half   <= 1'b1;
                end else begin
                    byte_o.valid <= 1'b1;
                    byte_o.data  <= {nib, lo_nib};
                    byte_o.sof   <= first;
                    byte_o.err   <= lo_err | nib_err;
                    first        <= 1'b0;
                    half         <= 1'b0;
                end
            end
        end
    end

    assert_byte_spacing_R5: assert property (@(posedge clk) disable iff (rst)
        byte_o.valid |=> !byte_o.valid);

    assert_sof_on_byte_R4: assert property (@(posedge clk) disable iff (rst)
        byte_o.sof |-> byte_o.valid);

    assert_align_on_eof_R7: assert property (@(posedge clk) disable iff (rst)
        end_o.align |-> end_o.eof);

    assert_eof_alone_R6: assert property (@(posedge clk) disable iff (rst)
        !(byte_o.valid && end_o.eof));

    assert_eof_pulse_R6: assert property (@(posedge clk) disable iff (rst)
        end_o.eof |=> !end_o.eof);

endmodule

// File: rtl/mii_rx_deframer.sv
module mii_rx_deframer
    import mii_rx_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic [NIB_W-1:0]  mii_nib,
    input  logic              mii_valid,
    input  logic              mii_error,
    output logic              out_valid,
    output logic [BYTE_W-1:0] out_data,
    output logic              out_sof,
    output logic              out_err,
    output logic              out_eof,
    output logic              out_align_err,
    output logic              out_no_sfd
);

    rx_state_e  state;
    logic       sfd_hit;
    byte_out_t  byte_q;
    frame_end_t end_q;

    mii_rx_sfd_hunt u_hunt (
        .clk       (clk),
        .rst       (rst),
        .nib       (mii_nib),
        .nib_valid (mii_valid),
        .state     (state),
        .sfd_hit   (sfd_hit),
        .no_sfd    (out_no_sfd)
    );

    mii_rx_nibble_pack u_pack (
        .clk       (clk),
        .rst       (rst),
        .state     (state),
        .sfd_hit   (sfd_hit),
        .nib       (mii_nib),
        .nib_valid (mii_valid),
        .nib_err   (mii_error),
        .byte_o    (byte_q),
        .end_o     (end_q)
    );

    assign out_valid     = byte_q.valid;
    assign out_data      = byte_q.data;
    assign out_sof       = byte_q.sof;
    assign out_err       = byte_q.err | end_q.err;
    assign out_eof       = end_q.eof;
    assign out_align_err = end_q.align;

    assert_nosfd_excl_R8: assert property (@(posedge clk) disable iff (rst)
        out_no_sfd |-> (!out_eof && !out_valid));

    assert_nosfd_pulse_R8: assert property (@(posedge clk) disable iff (rst)
        out_no_sfd |=> !out_no_sfd);

endmodule

// File: tb/tb_mii_rx_deframer.sv
module tb_mii_rx_deframer;

    typedef struct packed {
        logic [1:0]  kind;   // 0 byte, 1 end strobe, 2 no-delimiter pulse
        logic [7:0]  data;
        logic        sof;
        logic        err;
        logic        align;
        logic [31:0] cyc;
    } exp_t;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [3:0] mii_nib = 4'h0;
    logic       mii_valid = 1'b0;
    logic       mii_error = 1'b0;
    logic       out_valid, out_sof, out_err, out_eof, out_align_err, out_no_sfd;
    logic [7:0] out_data;

    int    checks = 0;
    int    fails = 0;
    int    cyc = 0;
    bit    done = 1'b0;
    string cur_case = "reset";
    exp_t  q[$];

    always #4 clk = ~clk;   // 125 MHz
    always @(posedge clk) cyc <= cyc + 1;

    mii_rx_deframer dut (
        .clk(clk), .rst(rst), .mii_nib(mii_nib), .mii_valid(mii_valid), .mii_error(mii_error),
        .out_valid(out_valid), .out_data(out_data), .out_sof(out_sof), .out_err(out_err),
        .out_eof(out_eof), .out_align_err(out_align_err), .out_no_sfd(out_no_sfd)
    );

    task automatic chk(input bit ok, input string tag, input string what, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s [%s] %s: actual %0h expected %0h", tag, cur_case, what, act, exp);
        end
    endtask

    task automatic push(input logic [1:0] k, input logic [7:0] d, input bit s, input bit e, input bit a);
        exp_t x;
        x.kind = k; x.data = d; x.sof = s; x.err = e; x.align = a; x.cyc = 32'(cyc + 1);
        q.push_back(x);
    endtask

    task automatic drive(input logic [3:0] n, input bit v, input bit e);
        @(negedge clk);
        mii_nib = n; mii_valid = v; mii_error = e;
    endtask

    // scoreboard monitor
    always @(negedge clk) begin
        if (!rst && !done && (out_valid || out_eof || out_no_sfd)) begin
            int   ak;
            exp_t x;
            ak = out_valid ? 0 : (out_eof ? 1 : 2);
            if (q.size() == 0) begin
                chk(1'b0, "R2", "unexpected strobe kind", ak, 3);
            end else begin
                x = q.pop_front();
                chk(ak == int'(x.kind), x.kind == 2'd2 ? "R8" : (x.kind == 2'd1 ? "R6" : "R2"),
                    "strobe kind", ak, int'(x.kind));
                if (ak == int'(x.kind)) begin
                    chk(cyc == int'(x.cyc), "R5", "strobe cycle", cyc, int'(x.cyc));
                    if (x.kind == 2'd0) begin
                        chk(out_data == x.data, "R3", "byte value", out_data, x.data);
                        chk(out_sof == x.sof, "R4", "sof flag", out_sof, x.sof);
                        chk(out_err == x.err, "R10", "byte error", out_err, x.err);
                    end else if (x.kind == 2'd1) begin
                        chk(out_err == x.err, "R10 R11", "frame error", out_err, x.err);
                        chk(out_align_err == x.align, "R7", "alignment flag", out_align_err, x.align);
                    end
                end
            end
        end
    end

    // pre_nib: count of 0x5 nibbles before 0xD (the last one is the delimiter's low half)
    task automatic run_frame(input int pre_nib, input int nbytes, input int seed, input bit odd,
                             input int er_nib, input bit er_pre, input bit er_tail, input int gap);
        int  nn;
        bit  ferr;
        nn   = 2 * nbytes + (odd ? 1 : 0);
        ferr = er_pre || (er_nib >= 0 && er_nib < nn);
        for (int i = 0; i < pre_nib; i++) drive(4'h5, 1'b1, er_pre && i == 0);
        drive(4'hD, 1'b1, 1'b0);
        for (int b = 0; b < nbytes; b++) begin
            logic [7:0] v;
            bit e0, e1;
            v  = 8'(seed * 7 + b * 29 + 3);
            e0 = (er_nib == 2 * b);
            e1 = (er_nib == 2 * b + 1);
            drive(v[3:0], 1'b1, e0);
            drive(v[7:4], 1'b1, e1);
            push(2'd0, v, b == 0, e0 | e1, 1'b0);
        end
        if (odd) drive(4'hA, 1'b1, er_nib == 2 * nbytes);
        drive(4'h0, 1'b0, er_tail);
        push(2'd1, 8'h00, 1'b0, ferr, odd);
        for (int g = 0; g < gap; g++) drive(4'h0, 1'b0, 1'b0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            chk(1'b0, "R6", "watchdog expired", 0, 1);
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1: all strobes clear after reset
        chk(!out_valid && !out_eof && !out_no_sfd && !out_sof && !out_err && !out_align_err,
            "R1", "outputs after reset",
            {out_valid, out_eof, out_no_sfd, out_sof, out_err, out_align_err}, 0);

        cur_case = "full preamble R2 R3 R4";
        run_frame(15, 6, 1, 1'b0, -1, 1'b0, 1'b0, 4);

        cur_case = "no preamble R9";
        run_frame(1, 4, 2, 1'b0, -1, 1'b0, 1'b0, 3);

        cur_case = "odd nibble R7";
        run_frame(4, 3, 3, 1'b1, -1, 1'b0, 1'b0, 3);

        cur_case = "payload error R10";
        run_frame(6, 4, 4, 1'b0, 3, 1'b0, 1'b0, 3);

        cur_case = "preamble error R10";
        run_frame(6, 2, 5, 1'b0, -1, 1'b1, 1'b0, 3);

        cur_case = "no delimiter R8";
        for (int i = 0; i < 6; i++) drive(4'h5, 1'b1, 1'b0);
        drive(4'h0, 1'b0, 1'b0);
        push(2'd2, 8'h00, 1'b0, 1'b0, 1'b0);
        drive(4'h0, 1'b0, 1'b0);
        drive(4'hD, 1'b1, 1'b0);   // lone 0xD right at the rise
        drive(4'h0, 1'b0, 1'b0);
        push(2'd2, 8'h00, 1'b0, 1'b0, 1'b0);
        repeat (3) drive(4'h0, 1'b0, 1'b0);

        cur_case = "hunt resync R2";
        drive(4'h5, 1'b1, 1'b0);
        drive(4'hA, 1'b1, 1'b0);
        drive(4'hD, 1'b1, 1'b0);   // not preceded by 0x5: keep hunting
        run_frame(3, 3, 6, 1'b0, -1, 1'b0, 1'b0, 3);

        cur_case = "error while idle R11";
        repeat (5) drive(4'h7, 1'b0, 1'b1);
        run_frame(2, 2, 7, 1'b0, -1, 1'b0, 1'b1, 3);

        cur_case = "back to back R6";
        run_frame(2, 1, 8, 1'b0, -1, 1'b0, 1'b0, 1);
        run_frame(2, 5, 9, 1'b1, 9, 1'b0, 1'b0, 1);

        cur_case = "empty frame R6 R7";
        run_frame(3, 0, 10, 1'b0, -1, 1'b0, 1'b0, 3);
        run_frame(3, 0, 11, 1'b1, -1, 1'b0, 1'b0, 4);

        repeat (4) @(negedge clk);
        cur_case = "drain";
        chk(q.size() == 0, "R6", "expected strobes missing", q.size(), 0);
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule